// File: doc/BRIEF.md
# Dual-Bank Rule Table with Versioned Atomic Swap

This block keeps a per-slice rule table as two complete banks. One bank is live and answers lookups. The other bank is a staging copy that software fills entry by entry and then tags with a version number. A validate command checks the staged copy against an external compile-status bit and a per-slice entry quota. A later switch command swaps the roles of the two banks in one clock edge. Each lookup therefore resolves against exactly one whole bank.

The bank that was live before a switch is left untouched, so a single rollback command can return to it. Each accepted switch or rollback increments an event counter and stores a timestamp taken from a free-running cycle counter. A rollback also stores the version that was restored and a caller-supplied reason code. After reset the block clears both banks one index per cycle. It raises its ready flag only when this clear has finished and the version fields match the cleared contents.

Lookups are indexed by a slice key of the form `{slice, rule}`. The result comes out one cycle later and carries the version of the bank that produced it.

Top module: `dual_bank_rule_table`

## Requirements
- R1: Entry writes (`wr_en`) and version tags (`tag_en`) change only the staging bank and the staging version. A lookup made after such writes, before any switch, returns the unchanged live result.
- R2: A lookup presented at one clock edge gives `res_valid` one cycle later. The result carries `res_hit` (the entry's live bit), `res_action` (the stored action on a hit, zero on a miss) and `res_ver` (the version of the bank that was read). A lookup in the same cycle as an accepted switch reads the old bank. The next cycle reads the new bank.
- R3: Validate (`cmd_op`=0) returns code 7 when an entry write or tag arrives in the same cycle. Otherwise it returns code 5 when `cmp_ok` is low. Otherwise it returns code 6 when any slice has more than QUOTA live entries in the staging bank. Otherwise it returns code 0. Only code 0 sets `shadow_ok`, and any later staging write or tag clears it.
- R4: Switch (`cmd_op`=1) is refused with code 2 when `shadow_ok` is low. It is refused with code 3 when the staging version is not strictly greater than the live version. A refused switch leaves the live bank and both versions unchanged.
- R5: An accepted switch (code 0) exchanges the bank roles and the two versions. The former live bank keeps its contents, so that a later validate and switch restore the same results.
- R6: Rollback (`cmd_op`=2) is accepted only after a successful switch with no staging write, tag or rollback since then. Otherwise it returns code 4. An accepted rollback swaps back, sets `rb_ver` to the restored version and latches `cmd_reason` on `rb_reason`.
- R7: Each accepted switch or rollback adds one to `ev_count`. It sets `ev_kind` (0 for a switch, 1 for a rollback) and sets `ev_ts` to the number of clock edges since reset release that came before the accepting edge.
- R8: After reset release, `ready` stays low for ENTRIES cycles while both banks are cleared. In that time commands return code 1 and lookups produce no result. Versions and counters reset to zero, and once high, `ready` stays high.
- R9: An entry write or tag in the same cycle as an accepted switch or rollback is dropped.
- R10: Each command with `cmd_op` 0, 1 or 2 gives exactly one `rsp_valid` pulse one cycle later. `cmd_op`=3 gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one staging entry |
| wr_key | input | KEY_W | Entry index {slice, rule} |
| wr_live | input | 1 | Entry live bit written |
| wr_action | input | ACT_W | Entry action written |
| tag_en | input | 1 | Load staging version |
| tag_ver | input | VER_W | Staging version value |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 validate, 1 switch, 2 rollback, 3 none |
| cmp_ok | input | 1 | Compile status used by validate |
| cmd_reason | input | REASON_W | Reason code recorded on rollback |
| rsp_valid | output | 1 | Command response strobe |
| rsp_code | output | 3 | Response code |
| lk_valid | input | 1 | Lookup strobe |
| lk_key | input | KEY_W | Lookup index |
| res_valid | output | 1 | Lookup result strobe |
| res_hit | output | 1 | Entry live in bank read |
| res_action | output | ACT_W | Action of hit entry |
| res_ver | output | VER_W | Version of bank read |
| active_ver | output | VER_W | Live version |
| shadow_ver | output | VER_W | Staging version |
| shadow_ok | output | 1 | Staging bank validated |
| ready | output | 1 | Tables and versions consistent |
| ev_count | output | CNT_W | Switch/rollback event id |
| ev_ts | output | TS_W | Timestamp of last event |
| ev_kind | output | 1 | Last event was rollback |
| rb_ver | output | VER_W | Version restored by last rollback |
| rb_reason | output | REASON_W | Reason of last rollback |

## Verification
A bank-select register that is flipped wrongly appears in `res_ver` of the very next lookup and in `active_ver` one cycle after the command. Lookup results are compared against a model of both banks, so a write that leaked into the live bank shows up as an unexpected hit on the next lookup of that key. A stale `shadow_ok` or rollback-available flag only shows when a later switch or rollback gets the wrong response code, one cycle after that command. For this reason each command is checked right after every staging write. Event-counter and timestamp faults are visible one cycle after each accepted swap.

// File: rtl/dbrt_pkg.sv
package dbrt_pkg;

  typedef enum logic [1:0] {
    OP_VALIDATE = 2'd0,
    OP_SWITCH   = 2'd1,
    OP_ROLLBACK = 2'd2,
    OP_NONE     = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RC_OK        = 3'd0,
    RC_NOT_READY = 3'd1,
    RC_NOT_VALID = 3'd2,
    RC_VER_STALE = 3'd3,
    RC_NO_ROLLBK = 3'd4,
    RC_COMPILE   = 3'd5,
    RC_QUOTA     = 3'd6,
    RC_BUSY      = 3'd7
  } rc_e;

  // number of set bits in a slice's live map
  function automatic logic [7:0] count_live(input logic [31:0] map);
    logic [7:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + 8'(map[i]);
    return n;
  endfunction

  function automatic logic within_quota(input logic [7:0] n, input int unsigned q);
    return (32'(n) <= q);
  endfunction

  // strict ordering of versions, no wrap handling
  function automatic logic ver_newer(input logic [31:0] cand, input logic [31:0] cur);
    return (cand > cur);
  endfunction

endpackage

// File: rtl/dbrt_banks.sv
module dbrt_banks #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 4,
  parameter int ACT_W   = 8
) (
  input  logic               clk,
  input  logic               active_sel,
  input  logic               clr_fire,
  input  logic [KEY_W-1:0]   clr_idx,
  input  logic               wr_fire,
  input  logic [KEY_W-1:0]   wr_idx,
  input  logic               wr_live,
  input  logic [ACT_W-1:0]   wr_act,
  input  logic [KEY_W-1:0]   rd_idx,
  output logic               rd_live,
  output logic [ACT_W-1:0]   rd_act,
  output logic [ENTRIES-1:0] shadow_map
);

  logic [1:0]         rd_live_b;
  logic [ACT_W-1:0]   rd_act_b  [2];
  logic [ENTRIES-1:0] live_map_b [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic BID = (b == 1);
    logic [ENTRIES-1:0] live_q;
    logic [ACT_W-1:0]   act_q [ENTRIES];

    // the live bank is never written; the clear sweep touches both
    always_ff @(posedge clk) begin
      if (clr_fire) begin
        live_q[clr_idx] <= 1'b0;
        act_q[clr_idx]  <= '0;
      end else if (wr_fire && (active_sel != BID)) begin
        live_q[wr_idx]  <= wr_live;
        act_q[wr_idx]   <= wr_act;
      end
    end

    assign rd_live_b[b]  = live_q[rd_idx];
    assign rd_act_b[b]   = act_q[rd_idx];
    assign live_map_b[b] = live_q;
  end

  assign rd_live    = rd_live_b[active_sel];
  assign rd_act     = rd_act_b[active_sel];
  assign shadow_map = live_map_b[~active_sel];

endmodule

// File: rtl/dbrt_quota.sv
module dbrt_quota #(
  parameter int SLICES = 4,
  parameter int RULES  = 4,
  parameter int QUOTA  = 3
) (
  input  logic [SLICES*RULES-1:0] live_map,
  output logic                    all_ok
);
  import dbrt_pkg::*;

  logic [SLICES-1:0] slice_ok;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    logic [7:0] n_live;
    assign n_live      = count_live(32'(live_map[s*RULES +: RULES]));
    assign slice_ok[s] = within_quota(n_live, QUOTA);
  end

  assign all_ok = &slice_ok;

endmodule

// File: rtl/dbrt_ctrl.sv
module dbrt_ctrl #(
  parameter int ENTRIES  = 16,
  parameter int KEY_W    = 4,
  parameter int VER_W    = 8,
  parameter int CNT_W    = 8,
  parameter int TS_W     = 16,
  parameter int REASON_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                tag_en,
  input  logic [VER_W-1:0]    tag_ver,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic                cmp_ok,
  input  logic [REASON_W-1:0] cmd_reason,
  input  logic                quota_ok,
  output logic                wr_fire,
  output logic                clr_fire,
  output logic [KEY_W-1:0]    clr_idx,
  output logic                active_sel,
  output logic                ready,
  output logic                rsp_valid,
  output logic [2:0]          rsp_code,
  output logic [VER_W-1:0]    active_ver,
  output logic [VER_W-1:0]    shadow_ver,
  output logic                shadow_ok,
  output logic [CNT_W-1:0]    ev_count,
  output logic [TS_W-1:0]     ev_ts,
  output logic                ev_kind,
  output logic [VER_W-1:0]    rb_ver,
  output logic [REASON_W-1:0] rb_reason
);
  import dbrt_pkg::*;

  logic                ready_q, active_sel_q, shadow_ok_q, rb_avail_q;
  logic [KEY_W-1:0]    init_idx_q;
  logic [VER_W-1:0]    active_ver_q, shadow_ver_q, rb_ver_q;
  logic [CNT_W-1:0]    ev_count_q;
  logic [TS_W-1:0]     ts_q, ev_ts_q;
  logic                ev_kind_q, rsp_valid_q;
  logic [2:0]          rsp_code_q;
  logic [REASON_W-1:0] rb_reason_q;

  op_e  op;
  rc_e  code;
  logic cmd_fire, shadow_touch, sw_ok, rb_ok, val_ok, flip, tag_fire;

  assign op           = op_e'(cmd_op);
  assign cmd_fire     = cmd_valid && (op != OP_NONE);
  assign shadow_touch = wr_en || tag_en;

  always_comb begin
    code = RC_OK;
    if (!ready_q) begin
      code = RC_NOT_READY;
    end else begin
      unique case (op)
        OP_VALIDATE: begin
          if (shadow_touch)   code = RC_BUSY;
          else if (!cmp_ok)   code = RC_COMPILE;
          else if (!quota_ok) code = RC_QUOTA;
        end
        OP_SWITCH: begin
          if (!shadow_ok_q) code = RC_NOT_VALID;
          else if (!ver_newer(32'(shadow_ver_q), 32'(active_ver_q))) code = RC_VER_STALE;
        end
        OP_ROLLBACK: begin
          if (!rb_avail_q) code = RC_NO_ROLLBK;
        end
        default: code = RC_OK;
      endcase
    end
  end

  // named internal events
  assign sw_ok    = cmd_fire && (op == OP_SWITCH)   && (code == RC_OK);
  assign rb_ok    = cmd_fire && (op == OP_ROLLBACK) && (code == RC_OK);
  assign val_ok   = cmd_fire && (op == OP_VALIDATE) && (code == RC_OK);
  assign flip     = sw_ok || rb_ok;
  assign wr_fire  = wr_en  && ready_q && !flip;
  assign tag_fire = tag_en && ready_q && !flip;
  assign clr_fire = !ready_q;
  assign clr_idx  = init_idx_q;

  // reset recovery sweep and free-running stamp
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q    <= 1'b0;
      init_idx_q <= '0;
      ts_q       <= '0;
    end else begin
      ts_q <= ts_q + 1'b1;
      if (!ready_q) begin
        init_idx_q <= init_idx_q + 1'b1;
        if (init_idx_q == KEY_W'(ENTRIES - 1)) ready_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_sel_q <= 1'b0;
      active_ver_q <= '0;
      shadow_ver_q <= '0;
      shadow_ok_q  <= 1'b0;
      rb_avail_q   <= 1'b0;
      ev_count_q   <= '0;
      ev_ts_q      <= '0;
      ev_kind_q    <= 1'b0;
      rb_ver_q     <= '0;
      rb_reason_q  <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_code_q   <= '0;
    end else begin
      rsp_valid_q <= cmd_fire;
      rsp_code_q  <= code;
      if (flip) begin
        active_sel_q <= ~active_sel_q;
        active_ver_q <= shadow_ver_q;
        shadow_ver_q <= active_ver_q;
        shadow_ok_q  <= 1'b0;
        rb_avail_q   <= sw_ok;
        ev_count_q   <= ev_count_q + 1'b1;
        ev_ts_q      <= ts_q;
        ev_kind_q    <= rb_ok;
        if (rb_ok) begin
          rb_ver_q    <= shadow_ver_q;
          rb_reason_q <= cmd_reason;
        end
      end else begin
        if (tag_fire) shadow_ver_q <= tag_ver;
        if (wr_fire || tag_fire) begin
          shadow_ok_q <= 1'b0;
          rb_avail_q  <= 1'b0;
        end else if (val_ok) begin
          shadow_ok_q <= 1'b1;
        end
      end
    end
  end

  assign active_sel = active_sel_q;
  assign ready      = ready_q;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_code   = rsp_code_q;
  assign active_ver = active_ver_q;
  assign shadow_ver = shadow_ver_q;
  assign shadow_ok  = shadow_ok_q;
  assign ev_count   = ev_count_q;
  assign ev_ts      = ev_ts_q;
  assign ev_kind    = ev_kind_q;
  assign rb_ver     = rb_ver_q;
  assign rb_reason  = rb_reason_q;

  // R7: every bank flip is one counted event
  p_flip_counted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_sel_q) |-> ev_count_q == CNT_W'($past(ev_count_q) + 1));

  // R4: the live bank only moves on a command issued while ready
  p_flip_needs_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_sel_q) |-> $past(cmd_valid && ready_q));

  // R4: an accepted switch always raises the live version
  p_switch_ver_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ok |=> active_ver_q > $past(active_ver_q));

  // R3: validated flag is only set by a validate command
  p_ok_from_validate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shadow_ok_q) |-> $past(cmd_valid && cmd_op == 2'd0));

  // R8: ready never drops once raised
  p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q);

endmodule

// File: rtl/dual_bank_rule_table.sv
module dual_bank_rule_table #(
  parameter int SLICES   = 4,
  parameter int RULES    = 4,
  parameter int QUOTA    = 3,
  parameter int ACT_W    = 8,
  parameter int VER_W    = 8,
  parameter int CNT_W    = 8,
  parameter int TS_W     = 16,
  parameter int REASON_W = 4,
  localparam int ENTRIES = SLICES * RULES,
  localparam int KEY_W   = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [KEY_W-1:0]    wr_key,
  input  logic                wr_live,
  input  logic [ACT_W-1:0]    wr_action,
  input  logic                tag_en,
  input  logic [VER_W-1:0]    tag_ver,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic                cmp_ok,
  input  logic [REASON_W-1:0] cmd_reason,
  output logic                rsp_valid,
  output logic [2:0]          rsp_code,
  input  logic                lk_valid,
  input  logic [KEY_W-1:0]    lk_key,
  output logic                res_valid,
  output logic                res_hit,
  output logic [ACT_W-1:0]    res_action,
  output logic [VER_W-1:0]    res_ver,
  output logic [VER_W-1:0]    active_ver,
  output logic [VER_W-1:0]    shadow_ver,
  output logic                shadow_ok,
  output logic                ready,
  output logic [CNT_W-1:0]    ev_count,
  output logic [TS_W-1:0]     ev_ts,
  output logic                ev_kind,
  output logic [VER_W-1:0]    rb_ver,
  output logic [REASON_W-1:0] rb_reason
);

  logic               wr_fire, clr_fire, active_sel, quota_ok, rd_live;
  logic [KEY_W-1:0]   clr_idx;
  logic [ACT_W-1:0]   rd_act;
  logic [ENTRIES-1:0] shadow_map;

  dbrt_banks #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .ACT_W(ACT_W)) u_banks (
    .clk        (clk),
    .active_sel (active_sel),
    .clr_fire   (clr_fire),
    .clr_idx    (clr_idx),
    .wr_fire    (wr_fire),
    .wr_idx     (wr_key),
    .wr_live    (wr_live),
    .wr_act     (wr_action),
    .rd_idx     (lk_key),
    .rd_live    (rd_live),
    .rd_act     (rd_act),
    .shadow_map (shadow_map)
  );

  dbrt_quota #(.SLICES(SLICES), .RULES(RULES), .QUOTA(QUOTA)) u_quota (
    .live_map (shadow_map),
    .all_ok   (quota_ok)
  );

  dbrt_ctrl #(
    .ENTRIES(ENTRIES), .KEY_W(KEY_W), .VER_W(VER_W), .CNT_W(CNT_W),
    .TS_W(TS_W), .REASON_W(REASON_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .tag_en     (tag_en),
    .tag_ver    (tag_ver),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmp_ok     (cmp_ok),
    .cmd_reason (cmd_reason),
    .quota_ok   (quota_ok),
    .wr_fire    (wr_fire),
    .clr_fire   (clr_fire),
    .clr_idx    (clr_idx),
    .active_sel (active_sel),
    .ready      (ready),
    .rsp_valid  (rsp_valid),
    .rsp_code   (rsp_code),
    .active_ver (active_ver),
    .shadow_ver (shadow_ver),
    .shadow_ok  (shadow_ok),
    .ev_count   (ev_count),
    .ev_ts      (ev_ts),
    .ev_kind    (ev_kind),
    .rb_ver     (rb_ver),
    .rb_reason  (rb_reason)
  );

  // lookup stage: bank select sampled at the same edge a switch lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_action <= '0;
      res_ver    <= '0;
    end else begin
      res_valid <= lk_valid && ready;
      if (lk_valid && ready) begin
        res_hit    <= rd_live;
        res_action <= rd_live ? rd_act : '0;
        res_ver    <= active_ver;
      end
    end
  end

  // R2: a result only follows a lookup accepted one cycle earlier
  p_result_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(lk_valid && ready));

endmodule

// File: tb/dual_bank_rule_table_tb_top.sv
module dual_bank_rule_table_tb_top;

  localparam int KW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 0, wr_live = 0, tag_en = 0, cmd_valid = 0, cmp_ok = 0, lk_valid = 0;
  logic [KW-1:0] wr_key = '0, lk_key = '0;
  logic [7:0] wr_action = '0, tag_ver = '0;
  logic [1:0] cmd_op = '0;
  logic [3:0] cmd_reason = '0;
  logic       rsp_valid, res_valid, res_hit, shadow_ok, ready, ev_kind;
  logic [2:0] rsp_code;
  logic [7:0] res_action, res_ver, active_ver, shadow_ver, ev_count, rb_ver;
  logic [15:0] ev_ts;
  logic [3:0] rb_reason;

  int errors = 0, checks = 0;
  int edges = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (!rst_n) edges <= 0; else edges <= edges + 1;

  dual_bank_rule_table dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_key(wr_key), .wr_live(wr_live),
    .wr_action(wr_action), .tag_en(tag_en), .tag_ver(tag_ver), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmp_ok(cmp_ok), .cmd_reason(cmd_reason), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .lk_valid(lk_valid), .lk_key(lk_key), .res_valid(res_valid),
    .res_hit(res_hit), .res_action(res_action), .res_ver(res_ver), .active_ver(active_ver),
    .shadow_ver(shadow_ver), .shadow_ok(shadow_ok), .ready(ready), .ev_count(ev_count),
    .ev_ts(ev_ts), .ev_kind(ev_kind), .rb_ver(rb_ver), .rb_reason(rb_reason)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; tag_en = 0; cmd_valid = 0; lk_valid = 0; cmp_ok = 0;
  endtask

  // drive one cycle of stimulus, then sample after the edge
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic put_entry(input int key, input bit live, input int act);
    @(negedge clk);
    wr_en = 1; wr_key = KW'(key); wr_live = live; wr_action = 8'(act);
    step();
  endtask

  task automatic put_tag(input int v);
    @(negedge clk);
    tag_en = 1; tag_ver = 8'(v);
    step();
  endtask

  task automatic command(input int op, input bit cok, input int reason);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'(op); cmp_ok = cok; cmd_reason = 4'(reason);
    step();
  endtask

  task automatic lookup(input int key);
    @(negedge clk);
    lk_valid = 1; lk_key = KW'(key);
    step();
  endtask

  task automatic t_reset();
    int cyc;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmd_valid = 1; cmd_op = 2'd0; cmp_ok = 1; lk_valid = 1; lk_key = 4'd5;
    step();
    chk("R8 cmd during init code", rsp_code, 1);
    chk("R8 lookup during init", res_valid, 0);
    chk("R8 ready low", ready, 0);
    cyc = 1;
    while (!ready && cyc < 100) begin @(negedge clk); cyc++; end
    chk("R8 clear cycles", cyc, 16);
    chk("R8 active_ver", active_ver, 0);
    chk("R8 ev_count", ev_count, 0);
    chk("R8 shadow_ok", shadow_ok, 0);
    lookup(5);
    chk("R8 cleared bank miss", res_hit, 0);
    chk("R2 result strobe", res_valid, 1);
  endtask

  task automatic t_stage();
    put_entry(5, 1, 'h5A);
    put_entry(9, 1, 'h9C);
    put_tag(3);
    lookup(5);
    chk("R1 staged write not live", res_hit, 0);
    chk("R1 live version kept", res_ver, 0);
    chk("R1 staging version", shadow_ver, 3);
  endtask

  task automatic t_refuse();
    command(1, 0, 0);
    chk("R4 unvalidated switch", rsp_code, 2);
    chk("R4 live unchanged", active_ver, 0);
    command(3, 0, 0);
    chk("R10 op 3 no response", rsp_valid, 0);
  endtask

  task automatic t_validate();
    command(0, 0, 0);
    chk("R3 compile fail", rsp_code, 5);
    chk("R10 response pulse", rsp_valid, 1);
    put_entry(8, 1, 1); put_entry(10, 1, 2); put_entry(11, 1, 3);
    command(0, 1, 0);
    chk("R3 over quota", rsp_code, 6);
    put_entry(11, 0, 0);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 0; cmp_ok = 1; wr_en = 1; wr_key = 0; wr_live = 0; wr_action = 0;
    step();
    chk("R3 busy when staging written", rsp_code, 7);
    chk("R3 busy leaves flag low", shadow_ok, 0);
    command(0, 1, 0);
    chk("R3 validate ok", rsp_code, 0);
    chk("R3 flag set", shadow_ok, 1);
  endtask

  task automatic t_stale();
    put_tag(0);
    chk("R3 tag clears flag", shadow_ok, 0);
    command(0, 1, 0);
    command(1, 0, 0);
    chk("R4 stale version", rsp_code, 3);
    chk("R4 live unchanged stale", active_ver, 0);
    put_tag(3);
    command(0, 1, 0);
  endtask

  task automatic t_switch();
    int k;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 1; lk_valid = 1; lk_key = 5;
    step();
    k = edges;
    chk("R5 switch accepted", rsp_code, 0);
    chk("R2 same-cycle lookup old bank ver", res_ver, 0);
    chk("R2 same-cycle lookup old bank miss", res_hit, 0);
    chk("R7 event count", ev_count, 1);
    chk("R7 event kind", ev_kind, 0);
    chk("R7 timestamp", ev_ts, (k - 1) & 16'hFFFF);
    chk("R5 versions swapped", active_ver, 3);
    chk("R5 staging holds old ver", shadow_ver, 0);
    lookup(5);
    chk("R2 new bank hit", res_hit, 1);
    chk("R2 new bank action", res_action, 'h5A);
    chk("R2 new bank ver", res_ver, 3);
  endtask

  task automatic t_rollback();
    int k;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2; cmd_reason = 4'hA;
    wr_en = 1; wr_key = 5; wr_live = 1; wr_action = 8'hEE;
    step();
    k = edges;
    chk("R6 rollback accepted", rsp_code, 0);
    chk("R6 live ver restored", active_ver, 0);
    chk("R6 rb_ver", rb_ver, 0);
    chk("R6 reason", rb_reason, 'hA);
    chk("R7 count after rollback", ev_count, 2);
    chk("R7 kind rollback", ev_kind, 1);
    chk("R7 rollback stamp", ev_ts, (k - 1) & 16'hFFFF);
    lookup(5);
    chk("R9 write during flip dropped", res_hit, 0);
    command(2, 0, 0);
    chk("R6 second rollback refused", rsp_code, 4);
  endtask

  task automatic t_forward();
    command(0, 1, 0);
    chk("R5 old bank revalidates", rsp_code, 0);
    command(1, 0, 0);
    chk("R5 forward switch", rsp_code, 0);
    lookup(9);
    chk("R5 former bank intact hit", res_hit, 1);
    chk("R5 former bank intact action", res_action, 'h9C);
    chk("R7 count forward", ev_count, 3);
    put_entry(0, 0, 0);
    command(2, 0, 0);
    chk("R6 rollback lost after staging write", rsp_code, 4);
    chk("R6 live unchanged", active_ver, 3);
  endtask

  initial begin
    t_reset();
    t_stage();
    t_refuse();
    t_validate();
    t_stale();
    t_switch();
    t_rollback();
    t_forward();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule